// File: doc/BRIEF.md
# Encoded Interrupt Level Masker

This block filters two 4-bit encoded interrupt-level inputs, a low group and a high group, against a word of per-level mask bits. Each group's pins carry an active-low pattern. The block inverts the pattern to form a request level, where level 0 means no request. Each group has one mask bit for each of its fifteen active levels. A group raises its filtered request, together with that level, only when four conditions hold: the group is in encoded mode, its coarse group mask is off, the level is nonzero, and that level's mask bit is clear.

The mask bits sit in one 32-bit word. Software sets bits through a write-one-to-set port and clears them through a separate write-one-to-clear port. A zero bit in either port leaves the matching mask bit as it was. The read port always shows the current mask state. A read that follows a set or clear write therefore confirms that the new mask is in effect. Priority arbitration, acknowledgement and input synchronisation belong to the surrounding controller.

Top module: `irl_level_mask`

## Requirements
- R1: After reset every mask bit reads 0.
- R2: A write on the set port with bit b at 1 sets mask bit b. Set-port bits at 0 leave their mask bits unchanged.
- R3: A write on the clear port with bit b at 1 clears mask bit b. Clear-port bits at 0 leave their mask bits unchanged.
- R4: Bits 16 and 0 are reserved. They always read 0, and writes on either port have no effect on them.
- R5: When the set port and the clear port hit the same bit in the same cycle, the bit ends up cleared.
- R6: Each group's level output is the bitwise inverse of its pin pattern. For low-group pin pattern p, the mask bit is bit 31-p. For high-group pin pattern p, the mask bit is bit 15-p.
- R7: A group whose encoded-mode input is 0 never raises its request.
- R8: A group whose coarse mask input is 1 never raises its request.
- R9: A pin pattern of all ones (level 0) never raises a request.
- R10: A mask update appears on the read port on the clock edge that ends the write cycle, and it gates the requests from that edge on. Without a write the mask word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| set_we | input | 1 | Set-port write strobe |
| set_data | input | 32 | Write-one-to-set data |
| clr_we | input | 1 | Clear-port write strobe |
| clr_data | input | 32 | Write-one-to-clear data |
| rd_data | output | 32 | Current mask word |
| lo_pins | input | 4 | Low-group active-low encoded pins |
| lo_encoded | input | 1 | Low group in encoded mode |
| lo_grp_mask | input | 1 | Low-group coarse mask |
| hi_pins | input | 4 | High-group active-low encoded pins |
| hi_encoded | input | 1 | High group in encoded mode |
| hi_grp_mask | input | 1 | High-group coarse mask |
| lo_req | output | 1 | Low-group filtered request |
| lo_level | output | 4 | Low-group request level |
| hi_req | output | 1 | High-group filtered request |
| hi_level | output | 4 | High-group request level |

## Verification
A set and a clear can land on the same mask bit in the same cycle. The bench provokes this with one vector that strobes both ports on bit 14. The vector also clears bit 31 while setting nothing there. After the edge the bench judges the read word, which must show both bits cleared. It also judges both requests: they must fire for the levels whose bits were just released.

// File: rtl/irl_level_mask.sv
module irl_level_mask #(
  parameter int LVL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_we,
  input  logic [2*(1<<LVL_W)-1:0] set_data,
  input  logic                   clr_we,
  input  logic [2*(1<<LVL_W)-1:0] clr_data,
  output logic [2*(1<<LVL_W)-1:0] rd_data,
  input  logic [LVL_W-1:0]       lo_pins,
  input  logic                   lo_encoded,
  input  logic                   lo_grp_mask,
  input  logic [LVL_W-1:0]       hi_pins,
  input  logic                   hi_encoded,
  input  logic                   hi_grp_mask,
  output logic                   lo_req,
  output logic [LVL_W-1:0]       lo_level,
  output logic                   hi_req,
  output logic [LVL_W-1:0]       hi_level
);
  localparam int GRP_W  = 1 << LVL_W;
  localparam int WORD_W = 2 * GRP_W;
  localparam logic [WORD_W-1:0] KEEP = ~((WORD_W'(1) << GRP_W) | WORD_W'(1));

  logic [WORD_W-1:0] mask_q;
  logic [WORD_W-1:0] set_v, clr_v;

  assign set_v = set_we ? set_data : '0;
  assign clr_v = clr_we ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= (mask_q | set_v) & ~clr_v & KEEP;
  end

  assign rd_data = mask_q;

  logic [1:0][LVL_W-1:0] pins, lvl;
  logic [1:0]            enc, gmask, req;

  assign pins  = {hi_pins, lo_pins};
  assign enc   = {hi_encoded, lo_encoded};
  assign gmask = {hi_grp_mask, lo_grp_mask};

  for (genvar g = 0; g < 2; g++) begin : gen_grp
    localparam int BASE = (g == 0) ? GRP_W : 0;
    logic [GRP_W-1:0] grp_bits;
    assign lvl[g]    = ~pins[g];
    assign grp_bits  = mask_q[BASE +: GRP_W];
    assign req[g]    = enc[g] & ~gmask[g] & (|lvl[g]) & ~grp_bits[lvl[g]];
  end

  assign lo_req   = req[0];
  assign hi_req   = req[1];
  assign lo_level = lvl[0];
  assign hi_level = lvl[1];
endmodule

module irl_level_mask_chk #(
  parameter int LVL_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    set_we,
  input logic [2*(1<<LVL_W)-1:0] set_data,
  input logic                    clr_we,
  input logic [2*(1<<LVL_W)-1:0] clr_data,
  input logic [2*(1<<LVL_W)-1:0] rd_data,
  input logic [LVL_W-1:0]        lo_pins,
  input logic                    lo_encoded,
  input logic                    lo_grp_mask,
  input logic [LVL_W-1:0]        hi_pins,
  input logic                    hi_encoded,
  input logic                    hi_grp_mask,
  input logic                    lo_req,
  input logic [LVL_W-1:0]        lo_level,
  input logic                    hi_req,
  input logic [LVL_W-1:0]        hi_level
);
  localparam int GRP_W  = 1 << LVL_W;
  localparam int WORD_W = 2 * GRP_W;
  localparam logic [WORD_W-1:0] KEEP = ~((WORD_W'(1) << GRP_W) | WORD_W'(1));

  assert_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[GRP_W] == 1'b0) && (rd_data[0] == 1'b0));

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((rd_data & $past(set_data & KEEP)) == $past(set_data & KEEP)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((rd_data & $past(clr_data)) == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(rd_data));

  assert_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_encoded |-> !lo_req) and (!hi_encoded |-> !hi_req));

  assert_coarse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_grp_mask |-> !lo_req) and (hi_grp_mask |-> !hi_req));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_pins == '1) |-> !lo_req) and ((hi_pins == '1) |-> !hi_req));

  assert_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_level == ~lo_pins) && (hi_level == ~hi_pins));
endmodule

bind irl_level_mask irl_level_mask_chk #(.LVL_W(LVL_W)) chk (.*);

// File: tb/irl_level_mask_test.sv
module irl_level_mask_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_we = 1'b0, clr_we = 1'b0;
  logic [31:0] set_data = '0, clr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  lo_pins = 4'hF, hi_pins = 4'hF;
  logic        lo_encoded = 1'b0, hi_encoded = 1'b0;
  logic        lo_grp_mask = 1'b0, hi_grp_mask = 1'b0;
  logic        lo_req, hi_req;
  logic [3:0]  lo_level, hi_level;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  irl_level_mask uut (
    .clk(clk), .rst_n(rst_n),
    .set_we(set_we), .set_data(set_data),
    .clr_we(clr_we), .clr_data(clr_data),
    .rd_data(rd_data),
    .lo_pins(lo_pins), .lo_encoded(lo_encoded), .lo_grp_mask(lo_grp_mask),
    .hi_pins(hi_pins), .hi_encoded(hi_encoded), .hi_grp_mask(hi_grp_mask),
    .lo_req(lo_req), .lo_level(lo_level),
    .hi_req(hi_req), .hi_level(hi_level)
  );

  typedef struct packed {
    logic        sw;
    logic [31:0] sd;
    logic        cw;
    logic [31:0] cd;
    logic [3:0]  lp;
    logic [3:0]  hp;
    logic        le;
    logic        he;
    logic        lg;
    logic        hg;
    logic [31:0] er;
    logic        elr;
    logic        ehr;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 32'h8000_8000, 1'b0, 32'h0,         4'h0, 4'h1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h8000_8000, 1'b0, 1'b1},
    '{1'b1, 32'h0001_0001, 1'b0, 32'h0,         4'hE, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 32'h8000_8000, 1'b1, 1'b0},
    '{1'b1, 32'h0000_4000, 1'b1, 32'h8000_4000, 4'h0, 4'h1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_8000, 1'b1, 1'b1},
    '{1'b1, 32'h0,         1'b1, 32'h0,         4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_8000, 1'b0, 1'b0},
    '{1'b1, 32'h0002_0004, 1'b0, 32'h0,         4'hE, 4'hD, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0002_8004, 1'b0, 1'b0},
    '{1'b0, 32'hFFFF_FFFF, 1'b0, 32'h0,         4'h5, 4'h5, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0002_8004, 1'b0, 1'b1},
    '{1'b0, 32'h0,         1'b1, 32'hFFFF_FFFF, 4'hE, 4'hD, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 1'b1},
    '{1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0,         4'h3, 4'h7, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFE_FFFE, 1'b0, 1'b0}
  };

  localparam string VTAG [8] = '{"R2 R6", "R4 R9", "R5 R3", "R2 R3 R7",
                                 "R2 R10", "R8 R10", "R3", "R2 R4"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    lo_encoded = 1'b1; hi_encoded = 1'b1;
    lo_pins = 4'h0; hi_pins = 4'h0;
    repeat (3) @(negedge clk);
    check("R1 reset mask", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mask after release", rd_data, 32'h0);
    check("R1 lo_req unmasked", {31'h0, lo_req}, 32'h1);

    for (int i = 0; i < 8; i++) begin
      set_we = VECS[i].sw; set_data = VECS[i].sd;
      clr_we = VECS[i].cw; clr_data = VECS[i].cd;
      lo_pins = VECS[i].lp; hi_pins = VECS[i].hp;
      lo_encoded = VECS[i].le; hi_encoded = VECS[i].he;
      lo_grp_mask = VECS[i].lg; hi_grp_mask = VECS[i].hg;
      @(negedge clk);
      check({VTAG[i], " rd_data"}, rd_data, VECS[i].er);
      check({VTAG[i], " lo_req"}, {31'h0, lo_req}, {31'h0, VECS[i].elr});
      check({VTAG[i], " hi_req"}, {31'h0, hi_req}, {31'h0, VECS[i].ehr});
      check("R6 lo_level", {28'h0, lo_level}, {28'h0, ~VECS[i].lp});
      check("R6 hi_level", {28'h0, hi_level}, {28'h0, ~VECS[i].hp});
    end

    // R10: write cycle itself still shows the old mask, next edge shows the new one
    set_we = 1'b0; clr_we = 1'b1; clr_data = 32'h0800_0000;
    lo_pins = 4'h4; lo_encoded = 1'b1; lo_grp_mask = 1'b0;
    #1;
    check("R10 before edge", {31'h0, lo_req}, 32'h0);
    @(negedge clk);
    clr_we = 1'b0;
    check("R10 after edge rd", rd_data, 32'hF7FE_FFFE);
    check("R10 after edge lo_req", {31'h0, lo_req}, 32'h1);

    // R7: high group out of encoded mode with an unmasked level
    hi_encoded = 1'b0; hi_pins = 4'hF;
    clr_we = 1'b1; clr_data = 32'h0000_0002;
    @(negedge clk);
    clr_we = 1'b0; hi_pins = 4'hE;
    #1;
    check("R7 hi_req off in plain mode", {31'h0, hi_req}, 32'h0);
    hi_encoded = 1'b1;
    #1;
    check("R7 hi_req on in encoded mode", {31'h0, hi_req}, 32'h1);

    // R1: reset mid-run wipes the mask
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule